// File: doc/BRIEF.md
# Seconds Real-Time Counter with Alarm

This block is a free-running seconds counter with a single alarm comparator, accessed through a small synchronous byte-wide register port. A 32-bit count advances by one on every tick pulse while the run bit is set, and wraps to zero after its maximum value. Software reads the live count as four little-endian bytes. These reads are not snapshotted, so software must re-read the low byte to catch a carry that happens between byte reads.

To set the time, software stages the upper three bytes and then writes the low byte. Writing the low byte commits all four bytes to the counter in one cycle. An alarm value of the same width is compared against the count on every cycle. When the alarm is enabled and the two values are equal, a sticky status bit is set. The interrupt output is that status bit gated by the alarm enable. Software clears the status by writing the bit low.

Register map, as byte offsets:

| Offset | Contents |
|---|---|
| 0 | Control register |
| 1 | Alarm status |
| 2 to 5 | Time-write bytes |
| 6 to 9 | Time-read bytes |
| 10 to 13 | Alarm bytes |

Top module: `sec_rtc`

## Requirements
- R1: After reset every register reads 0 at every offset and `irq_o` is low.
- R2: Control bit 7 (offset 0) is the run bit; while it is 0, tick pulses leave the count unchanged.
- R3: While the run bit is 1, each cycle with `tick_i` high adds one to the count, and 0xFFFFFFFF wraps to 0x00000000.
- R4: Writes to offsets 3, 4 and 5 only stage count bits 15:8, 23:16 and 31:24 and leave the count unchanged. A write to offset 2 loads the count with the written byte in bits 7:0 and the three staged bytes above it, in the cycle of the write.
- R5: A load through offset 2 takes priority over a tick in the same cycle; the tick is lost.
- R6: Offsets 6 to 9 return count bytes 0 to 3, little-endian, straight from the live counter. A byte read after a tick reflects any carry out of a lower byte.
- R7: Offsets 10 to 13 hold alarm bytes 0 to 3, little-endian, and read back what was written.
- R8: Control bit 1 is the alarm enable. When it is 1 and the count equals the alarm value in a cycle, bit 0 of offset 1 (the status bit) reads 1 from the next cycle on.
- R9: Writing offset 1 with bit 0 low clears the status bit, unless a match occurs in the same cycle, in which case the bit stays set. Writing bit 0 high never sets the bit.
- R10: `irq_o` is high exactly when the status bit and the alarm enable are both 1. Clearing the enable drops `irq_o` and keeps the status bit.
- R11: Offsets 14 and 15 and the time-write offsets 2 to 5 read 0, and writes to offsets 14 and 15 have no effect. The control register reads only bits 7 and 1; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the register at `addr_i` |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| tick_i | input | 1 | One-cycle seconds pulse |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions assume that `tick_i` and `we_i` are single-cycle qualifiers sampled on every clock edge. They also assume that `addr_i` and `wdata_i` are meaningful only while `we_i` is high. The bench changes inputs only at the falling edge and drops `we_i` and `tick_i` after every step, so each write and each tick acts in exactly one cycle.

Random stimulus covers all 16 offsets, including unmapped ones. It biases control writes toward leaving the counter running. It also writes alarm bytes near the live count, so that matches and status clears occur alongside loads and ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned OFS_CTRL    = 0;
  localparam int unsigned OFS_ACTL    = 1;
  localparam int unsigned OFS_TW_BASE = 2;
  localparam int unsigned RUN_BIT     = 7;
  localparam int unsigned AEN_BIT     = 1;
  localparam int unsigned STAT_BIT    = 0;
endpackage

// File: rtl/rtc_byte_reg.sv
module rtc_byte_reg #(
  parameter int unsigned N_BYTES = 3,
  parameter int unsigned DATA_W  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_BYTES-1:0]        we_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [N_BYTES*DATA_W-1:0] q_o
);
  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      byte_q <= '0;
      else if (we_i[g]) byte_q <= wdata_i;
    end
    assign q_o[g*DATA_W +: DATA_W] = byte_q;
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  // load wins over tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              count_q <= '0;
    else if (load_i)          count_q <= load_val_i;
    else if (run_i && tick_i) count_q <= count_q + CNT_W'(1);
  end

  assign count_o = count_q;
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ctrl_i,
  input  logic wr_actl_i,
  input  logic run_d_i,
  input  logic aen_d_i,
  input  logic stat_d_i,
  input  logic hit_i,
  output logic run_o,
  output logic aen_o,
  output logic stat_o
);
  logic run_q, aen_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      aen_q <= 1'b0;
    end else if (wr_ctrl_i) begin
      run_q <= run_d_i;
      aen_q <= aen_d_i;
    end
  end

  // match sets; software can only clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     stat_q <= 1'b0;
    else if (hit_i)                  stat_q <= 1'b1;
    else if (wr_actl_i && !stat_d_i) stat_q <= 1'b0;
  end

  assign run_o  = run_q;
  assign aen_o  = aen_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             aen_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] alarm_i,
  output logic             hit_o
);
  assign hit_o = aen_i && (count_i == alarm_i);
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned N_BYTES = 4,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  output logic              irq_o
);
  localparam int unsigned CNT_W   = DATA_W * N_BYTES;
  localparam int unsigned TW_BASE = OFS_TW_BASE;
  localparam int unsigned TR_BASE = TW_BASE + N_BYTES;
  localparam int unsigned AL_BASE = TR_BASE + N_BYTES;
  localparam int unsigned N_REGS  = AL_BASE + N_BYTES;

  initial begin
    if (N_REGS > (1 << ADDR_W)) $error("ADDR_W too small for register map");
    if (DATA_W <= RUN_BIT)      $error("DATA_W too small for control bits");
  end

  logic [N_BYTES-2:0]          st_we;
  logic [N_BYTES-1:0]          al_we;
  logic [(N_BYTES-1)*DATA_W-1:0] stage_q;
  logic [CNT_W-1:0]            count_q;
  logic [CNT_W-1:0]            alarm_q;
  logic                        load;
  logic                        wr_ctrl, wr_actl;
  logic                        run_en, alm_en, stat_q, hit;
  logic [DATA_W-1:0]           rdata;

  // write decode
  assign load    = we_i && (addr_i == ADDR_W'(TW_BASE));
  assign wr_ctrl = we_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_actl = we_i && (addr_i == ADDR_W'(OFS_ACTL));

  for (genvar g = 1; g < N_BYTES; g++) begin : g_st_we
    assign st_we[g-1] = we_i && (addr_i == ADDR_W'(TW_BASE + g));
  end

  for (genvar g = 0; g < N_BYTES; g++) begin : g_al_we
    assign al_we[g] = we_i && (addr_i == ADDR_W'(AL_BASE + g));
  end

  rtc_byte_reg #(.N_BYTES(N_BYTES-1), .DATA_W(DATA_W)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (st_we),
    .wdata_i (wdata_i),
    .q_o     (stage_q)
  );

  rtc_byte_reg #(.N_BYTES(N_BYTES), .DATA_W(DATA_W)) u_alarm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (al_we),
    .wdata_i (wdata_i),
    .q_o     (alarm_q)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_en),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i ({stage_q, wdata_i}),
    .count_o    (count_q)
  );

  rtc_alarm_cmp #(.CNT_W(CNT_W)) u_cmp (
    .aen_i   (alm_en),
    .count_i (count_q),
    .alarm_i (alarm_q),
    .hit_o   (hit)
  );

  rtc_ctrl_regs u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (wr_ctrl),
    .wr_actl_i (wr_actl),
    .run_d_i   (wdata_i[RUN_BIT]),
    .aen_d_i   (wdata_i[AEN_BIT]),
    .stat_d_i  (wdata_i[STAT_BIT]),
    .hit_i     (hit),
    .run_o     (run_en),
    .aen_o     (alm_en),
    .stat_o    (stat_q)
  );

  // read mux: live count, no snapshot
  always_comb begin
    rdata = '0;
    if (addr_i == ADDR_W'(OFS_CTRL)) begin
      rdata[RUN_BIT] = run_en;
      rdata[AEN_BIT] = alm_en;
    end
    if (addr_i == ADDR_W'(OFS_ACTL)) rdata[STAT_BIT] = stat_q;
    for (int b = 0; b < N_BYTES; b++) begin
      if (addr_i == ADDR_W'(TR_BASE + b)) rdata = count_q[b*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(AL_BASE + b)) rdata = alarm_q[b*DATA_W +: DATA_W];
    end
  end

  assign rdata_o = rdata;
  assign irq_o   = stat_q & alm_en;
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned N_BYTES = 4,
  parameter int unsigned ADDR_W  = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       we_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [DATA_W-1:0]          wdata_i,
  input logic                       tick_i,
  input logic                       irq_o,
  input logic [DATA_W*N_BYTES-1:0]  count_q,
  input logic [DATA_W*N_BYTES-1:0]  alarm_q,
  input logic                       stat_q,
  input logic                       run_en,
  input logic                       alm_en
);
  localparam int unsigned CNT_W = DATA_W * N_BYTES;

  logic ld, clr, match;
  assign ld    = we_i && (addr_i == ADDR_W'(OFS_TW_BASE));
  assign clr   = we_i && (addr_i == ADDR_W'(OFS_ACTL)) && !wdata_i[STAT_BIT];
  assign match = alm_en && (count_q == alarm_q);

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en && !ld) |=> $stable(count_q));

  // R3
  tick_increment_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en && tick_i && !ld) |=> count_q == $past(count_q) + CNT_W'(1));

  // R4 R5
  load_low_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> count_q[DATA_W-1:0] == $past(wdata_i));

  // R8
  match_sets_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> stat_q);

  // R9
  status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !clr) |=> stat_q);

  // R9
  status_no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_q && !match) |=> !stat_q);

  // R10
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alm_en |-> !irq_o);
endmodule

bind sec_rtc sec_rtc_chk #(.DATA_W(DATA_W), .N_BYTES(N_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .tick_i  (tick_i),
  .irq_o   (irq_o),
  .count_q (count_q),
  .alarm_q (alarm_q),
  .stat_q  (stat_q),
  .run_en  (run_en),
  .alm_en  (alm_en)
);

// File: tb/tb_sec_rtc.sv
module tb_sec_rtc;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       we;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       tick;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // model state
  logic [31:0] m_cnt, m_alarm;
  logic [23:0] m_stage;
  logic        m_run, m_aen, m_stat;

  always #(CLK_P/2) clk = ~clk;

  sec_rtc dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .tick_i  (tick),
    .irq_o   (irq)
  );

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0:  return {m_run, 5'b0, m_aen, 1'b0};
      4'd1:  return {7'b0, m_stat};
      4'd6:  return m_cnt[7:0];
      4'd7:  return m_cnt[15:8];
      4'd8:  return m_cnt[23:16];
      4'd9:  return m_cnt[31:24];
      4'd10: return m_alarm[7:0];
      4'd11: return m_alarm[15:8];
      4'd12: return m_alarm[23:16];
      4'd13: return m_alarm[31:24];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_edge(input logic w, input logic [3:0] a, input logic [7:0] d, input logic t);
    logic ev;
    ev = m_aen && (m_cnt == m_alarm);
    if (ev) m_stat = 1'b1;
    else if (w && a == 4'd1 && !d[0]) m_stat = 1'b0;
    if (w && a == 4'd2) m_cnt = {m_stage, d};
    else if (m_run && t) m_cnt = m_cnt + 32'd1;
    if (w) begin
      case (a)
        4'd0:  begin m_run = d[7]; m_aen = d[1]; end
        4'd3:  m_stage[7:0]   = d;
        4'd4:  m_stage[15:8]  = d;
        4'd5:  m_stage[23:16] = d;
        4'd10: m_alarm[7:0]   = d;
        4'd11: m_alarm[15:8]  = d;
        4'd12: m_alarm[23:16] = d;
        4'd13: m_alarm[31:24] = d;
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] a, input logic [7:0] d, input logic t);
    we = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
    model_edge(w, a, d, t);
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, {24'h0, rdata}, {24'h0, exp});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_cnt = '0; m_alarm = '0; m_stage = '0;
    m_run = 0; m_aen = 0; m_stat = 0;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) rd(4'(a), 8'h00, "R1 reset read");
    chk("R1 irq after reset", {31'b0, irq}, 32'd0);

    // R4 staging only, then commit by low byte
    step(1, 4'd3, 8'h22, 0);
    step(1, 4'd4, 8'h33, 0);
    step(1, 4'd5, 8'h44, 0);
    rd(4'd9, 8'h00, "R4 staging leaves count");
    rd(4'd7, 8'h00, "R4 staging leaves count");
    step(1, 4'd2, 8'h11, 0);
    rd(4'd6, 8'h11, "R4 load byte0");
    rd(4'd7, 8'h22, "R4 load byte1");
    rd(4'd8, 8'h33, "R4 load byte2");
    rd(4'd9, 8'h44, "R4 load byte3");

    // R2 ticks ignored while stopped
    step(0, 4'd0, 8'h00, 1);
    step(0, 4'd0, 8'h00, 1);
    rd(4'd6, 8'h11, "R2 stopped counter holds");

    // R3 run and tick
    step(1, 4'd0, 8'h80, 0);
    step(0, 4'd0, 8'h00, 1);
    rd(4'd6, 8'h12, "R3 increment");

    // R5 load beats tick
    step(1, 4'd3, 8'hFF, 0);
    step(1, 4'd4, 8'hFF, 0);
    step(1, 4'd5, 8'hFF, 0);
    step(1, 4'd2, 8'hFF, 1);
    rd(4'd6, 8'hFF, "R5 load over tick byte0");
    rd(4'd9, 8'hFF, "R5 load over tick byte3");

    // R3 wrap
    step(0, 4'd0, 8'h00, 1);
    rd(4'd6, 8'h00, "R3 wrap byte0");
    rd(4'd9, 8'h00, "R3 wrap byte3");

    // R6 carry seen between byte reads
    step(1, 4'd3, 8'h00, 0);
    step(1, 4'd4, 8'h00, 0);
    step(1, 4'd5, 8'h00, 0);
    step(1, 4'd2, 8'hFF, 0);
    rd(4'd6, 8'hFF, "R6 low byte before carry");
    rd(4'd7, 8'h00, "R6 byte1 before carry");
    step(0, 4'd0, 8'h00, 1);
    rd(4'd7, 8'h01, "R6 byte1 after carry");
    rd(4'd6, 8'h00, "R6 low byte after carry");

    // R7 alarm bytes
    step(1, 4'd10, 8'h05, 0);
    step(1, 4'd11, 8'h01, 0);
    step(1, 4'd12, 8'h00, 0);
    step(1, 4'd13, 8'hA5, 0);
    rd(4'd10, 8'h05, "R7 alarm byte0");
    rd(4'd13, 8'hA5, "R7 alarm byte3");
    step(1, 4'd13, 8'h00, 0);
    rd(4'd11, 8'h01, "R7 alarm byte1");

    // R8 match timing: count 0x100 -> 0x105
    step(1, 4'd0, 8'h82, 0);
    for (int i = 0; i < 5; i++) step(0, 4'd0, 8'h00, 1);
    rd(4'd6, 8'h05, "R8 count reached alarm");
    rd(4'd1, 8'h00, "R8 status not yet set");
    chk("R10 irq low before status", {31'b0, irq}, 32'd0);
    idle(1);
    rd(4'd1, 8'h01, "R8 status set next cycle");
    chk("R10 irq high", {31'b0, irq}, 32'd1);

    // R9 clear with concurrent match keeps status
    step(1, 4'd1, 8'h00, 0);
    rd(4'd1, 8'h01, "R9 match wins over clear");
    step(0, 4'd0, 8'h00, 1);
    step(1, 4'd1, 8'h00, 0);
    rd(4'd1, 8'h00, "R9 clear");
    chk("R10 irq low after clear", {31'b0, irq}, 32'd0);
    step(1, 4'd1, 8'h01, 0);
    rd(4'd1, 8'h00, "R9 write one does not set");

    // R10 disabling alarm drops irq, keeps status
    step(1, 4'd3, 8'h01, 0);
    step(1, 4'd2, 8'h05, 0);
    idle(1);
    chk("R10 irq on rematch", {31'b0, irq}, 32'd1);
    step(1, 4'd0, 8'h80, 0);
    chk("R10 irq off with enable low", {31'b0, irq}, 32'd0);
    rd(4'd1, 8'h01, "R10 status kept");

    // R11 unmapped and unused bits
    step(1, 4'd14, 8'h5A, 0);
    step(1, 4'd15, 8'hA5, 0);
    rd(4'd14, 8'h00, "R11 unmapped read");
    rd(4'd15, 8'h00, "R11 unmapped read");
    rd(4'd10, 8'h05, "R11 unmapped write no effect");
    rd(4'd3, 8'h00, "R11 write-only read");
    step(1, 4'd0, 8'hFF, 0);
    rd(4'd0, 8'h82, "R11 control unused bits");

    // random phase checked against model (R3 R6 R7 R8 R9 R10)
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] a;
      logic [7:0] d;
      logic       w, t;
      a = 4'($urandom % 16);
      d = 8'($urandom);
      w = ($urandom % 3) == 0;
      t = ($urandom % 2) == 0;
      if (a == 4'd0 && ($urandom % 5) != 0) d[7] = 1'b1;
      if (a >= 4'd10 && a <= 4'd13 && ($urandom % 2) == 0)
        d = m_cnt[(a-4'd10)*8 +: 8] + 8'(($urandom % 3));
      step(w, a, d, t);
      chk("R10 random irq", {31'b0, irq}, {31'b0, m_stat & m_aen});
      a = 4'($urandom % 16);
      rd(a, exp_rd(a), "R6 R7 R8 random read");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule